// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block keeps the interrupt bookkeeping for every channel of a multi-channel DMA engine. Each channel receives single-cycle event pulses on a group of event lines. Bit 0 is transfer done, bit 1 is suspend complete, and bits 2 and up are error sources. A per-channel record mask picks which events are captured into a sticky status register. A second per-channel mask, the raise mask, picks which captured bits drive that channel's interrupt line. Software removes captured bits by writing ones to a clear register.

One global enable bit gates the OR of all channel lines onto the controller interrupt output. This bit never changes any status. Because capture and signalling are masked separately, software can record an event such as suspend complete and poll for it without taking an interrupt.

Each channel also reports a two-bit cause summary. In this summary, any captured error takes priority over transfer done. Registers are reached through a single write port and a combinational read port. The address is {global select, channel index, register offset}.

Top module: `chan_irq_hub`

## Requirements
- R1: After reset, every status, record mask, raise mask and the global enable are zero. irq_o, every irq_chan_o bit and every cause code are zero.
- R2: An event bit is captured into channel status only when the matching record-mask bit is set in that cycle. A captured bit stays set after the pulse ends.
- R3: While a channel's record mask is all zeros, no event pulse changes that channel's status.
- R4: irq_chan_o[c] is high exactly when status AND raise mask of channel c is non-zero. A status bit whose raise bit is clear, such as suspend complete at bit 1, can be read back without raising the line.
- R5: Writing to the clear register (offset 3) clears each status bit written as one and leaves each bit written as zero unchanged.
- R6: When an enabled event and a clear of the same bit fall in the same cycle, the bit remains set.
- R7: irq_o equals the global enable (address bit AW-1 set, data bit 0) ANDed with the OR of all irq_chan_o. Changing the global enable alters no status.
- R8: cause_o[2c+1:2c] is 2'b10 when any error bit (bit 2 and up) of channel c status is set. Otherwise it is 2'b01 when bit 0 is set, and 2'b00 in all other cases. It is never 2'b11.
- R9: Offsets 1 and 2 read back the record and raise masks, offset 0 reads status, and offset 3 reads as zero.
- R10: A write addressed to one channel leaves every other channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_i | input | NCH*EVW | Event pulses, channel c in bits [c*EVW +: EVW] |
| wr_i | input | 1 | Write strobe |
| addr_i | input | AW | Register address {global, channel, offset} |
| wdata_i | input | EVW | Write data |
| rdata_o | output | EVW | Combinational read data for addr_i |
| irq_o | output | 1 | Gated controller interrupt |
| irq_chan_o | output | NCH | Per-channel interrupt lines before global gating |
| cause_o | output | 2*NCH | Per-channel cause summary |

## Verification
The bench covers an event that lands in the same cycle as a clear of its own bit. A design that lets the clear win would lose that event. It covers an all-zero record mask facing a burst of events, which a design that ignores the mask would latch. It covers a suspend bit that is captured but not raised, which a design sharing one mask would wrongly signal. It toggles the global enable to confirm it gates only irq_o and leaves status untouched. It sets an error and a done bit together, where a wrong priority would report done. It writes to one channel and reads a neighbour, which exposes address decode that leaks across channels.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_DONE = 2'b01,
    CAUSE_ERR  = 2'b10
  } cause_e;

  localparam logic [1:0] OFS_STAT = 2'd0;
  localparam logic [1:0] OFS_REC  = 2'd1;
  localparam logic [1:0] OFS_RAI  = 2'd2;
  localparam logic [1:0] OFS_CLR  = 2'd3;

  localparam int DONE_BIT = 0;
  localparam int SUSP_BIT = 1;
  localparam int ERR_LO   = 2;
endpackage

// File: rtl/chan_irq_slice.sv
module chan_irq_slice
  import chan_irq_pkg::*;
#(
  parameter int EVW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [EVW-1:0] ev,
  input  logic           we_rec,
  input  logic           we_rai,
  input  logic           we_clr,
  input  logic [EVW-1:0] wdata,
  output logic [EVW-1:0] stat_q,
  output logic [EVW-1:0] rec_q,
  output logic [EVW-1:0] rai_q,
  output logic           line,
  output logic [1:0]     cause
);
  localparam int NERR = EVW - ERR_LO;

  logic [EVW-1:0] stat_d, rec_d, rai_d, clr_mask;

  always_comb begin
    clr_mask = we_clr ? wdata : '0;
    stat_d   = (stat_q & ~clr_mask) | (ev & rec_q);
    rec_d    = we_rec ? wdata : rec_q;
    rai_d    = we_rai ? wdata : rai_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      rec_q  <= '0;
      rai_q  <= '0;
    end else begin
      stat_q <= stat_d;
      rec_q  <= rec_d;
      rai_q  <= rai_d;
    end
  end

  always_comb begin
    line = |(stat_q & rai_q);
    if (|stat_q[ERR_LO +: NERR])  cause = CAUSE_ERR;
    else if (stat_q[DONE_BIT])    cause = CAUSE_DONE;
    else                          cause = CAUSE_NONE;
  end
endmodule

// File: rtl/chan_irq_regport.sv
module chan_irq_regport
  import chan_irq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int EVW = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW = CW + 3
) (
  input  logic               wr,
  input  logic [AW-1:0]      addr,
  input  logic [NCH*EVW-1:0] stat_flat,
  input  logic [NCH*EVW-1:0] rec_flat,
  input  logic [NCH*EVW-1:0] rai_flat,
  input  logic               gen_q,
  output logic [NCH-1:0]     we_rec,
  output logic [NCH-1:0]     we_rai,
  output logic [NCH-1:0]     we_clr,
  output logic               we_gen,
  output logic [EVW-1:0]     rdata
);
  logic          glob;
  logic [CW-1:0] ch;
  logic [1:0]    ofs;

  assign glob = addr[AW-1];
  assign ch   = addr[2 +: CW];
  assign ofs  = addr[1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    logic hit;
    assign hit       = wr && !glob && (ch == CW'(c));
    assign we_rec[c] = hit && (ofs == OFS_REC);
    assign we_rai[c] = hit && (ofs == OFS_RAI);
    assign we_clr[c] = hit && (ofs == OFS_CLR);
  end
  assign we_gen = wr && glob;

  always_comb begin
    rdata = '0;
    if (glob) begin
      rdata[0] = gen_q;
    end else if (int'(ch) < NCH) begin
      unique case (ofs)
        OFS_STAT: rdata = stat_flat[int'(ch)*EVW +: EVW];
        OFS_REC:  rdata = rec_flat[int'(ch)*EVW +: EVW];
        OFS_RAI:  rdata = rai_flat[int'(ch)*EVW +: EVW];
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/chan_irq_hub.sv
module chan_irq_hub
  import chan_irq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int EVW = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW = CW + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH*EVW-1:0] ev_i,
  input  logic               wr_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [EVW-1:0]     wdata_i,
  output logic [EVW-1:0]     rdata_o,
  output logic               irq_o,
  output logic [NCH-1:0]     irq_chan_o,
  output logic [2*NCH-1:0]   cause_o
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NCH*EVW-1:0] stat_flat, rec_flat, rai_flat;
  logic [NCH-1:0]     we_rec, we_rai, we_clr;
  logic               we_gen, gen_q, gen_d;

  chan_irq_regport #(.NCH(NCH), .EVW(EVW)) u_port (
    .wr(wr_i), .addr(addr_i),
    .stat_flat(stat_flat), .rec_flat(rec_flat), .rai_flat(rai_flat),
    .gen_q(gen_q),
    .we_rec(we_rec), .we_rai(we_rai), .we_clr(we_clr), .we_gen(we_gen),
    .rdata(rdata_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_irq_slice #(.EVW(EVW)) u_slice (
      .clk(clk), .rst_n(rst_sync_n),
      .ev(ev_i[c*EVW +: EVW]),
      .we_rec(we_rec[c]), .we_rai(we_rai[c]), .we_clr(we_clr[c]),
      .wdata(wdata_i),
      .stat_q(stat_flat[c*EVW +: EVW]),
      .rec_q(rec_flat[c*EVW +: EVW]),
      .rai_q(rai_flat[c*EVW +: EVW]),
      .line(irq_chan_o[c]),
      .cause(cause_o[2*c +: 2])
    );
  end

  assign gen_d = we_gen ? wdata_i[0] : gen_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) gen_q <= 1'b0;
    else             gen_q <= gen_d;
  end

  assign irq_o = gen_q & (|irq_chan_o);
endmodule

// File: rtl/chan_irq_hub_chk.sv
module chan_irq_hub_chk #(
  parameter int NCH = 4,
  parameter int EVW = 8
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic [NCH*EVW-1:0] ev_i,
  input logic [NCH*EVW-1:0] stat_flat,
  input logic [NCH*EVW-1:0] rec_flat,
  input logic               gen_q,
  input logic               irq_o,
  input logic [NCH-1:0]     irq_chan_o,
  input logic [2*NCH-1:0]   cause_o
);
  // R1
  always @(posedge clk) if (!rst_sync_n) begin
    reset_quiet_chk: assert (!irq_o && irq_chan_o == '0 && cause_o == '0);
  end

  // R7
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !gen_q |-> !irq_o);

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o |-> (irq_chan_o != '0));

  // R4
  line_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_chan_o != '0) |-> (stat_flat != '0));

  // R6
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((ev_i & rec_flat) != '0) |=>
      ((stat_flat & $past(ev_i & rec_flat)) == $past(ev_i & rec_flat)));

  // R3
  no_record_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rec_flat == '0) |=> ((stat_flat & ~$past(stat_flat)) == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R8
    cause_legal_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      cause_o[2*c +: 2] != 2'b11);
    // R8
    err_first_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (|stat_flat[c*EVW+2 +: EVW-2]) |-> (cause_o[2*c +: 2] == 2'b10));
  end
endmodule

bind chan_irq_hub chan_irq_hub_chk #(.NCH(NCH), .EVW(EVW)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .ev_i(ev_i),
  .stat_flat(stat_flat), .rec_flat(rec_flat), .gen_q(gen_q),
  .irq_o(irq_o), .irq_chan_o(irq_chan_o), .cause_o(cause_o)
);

// File: tb/chan_irq_hub_test.sv
module chan_irq_hub_test;
  localparam int CLK_NS = 10;
  localparam int NCH = 4;
  localparam int EVW = 8;
  localparam int AW  = 5;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [NCH*EVW-1:0] ev_i;
  logic               wr_i;
  logic [AW-1:0]      addr_i;
  logic [EVW-1:0]     wdata_i;
  logic [EVW-1:0]     rdata_o;
  logic               irq_o;
  logic [NCH-1:0]     irq_chan_o;
  logic [2*NCH-1:0]   cause_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  chan_irq_hub #(.NCH(NCH), .EVW(EVW)) uut (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .irq_chan_o(irq_chan_o), .cause_o(cause_o)
  );

  // {wr, waddr, wdata, chan0 events, raddr, expected}
  localparam logic [34:0] VECS [14] = '{
    {1'b1, 5'h01, 8'h00, 8'hFF, 5'h00, 8'h00},  // R3 record mask zero
    {1'b1, 5'h01, 8'h0F, 8'h00, 5'h01, 8'h0F},  // R9 record readback
    {1'b0, 5'h00, 8'h00, 8'hFF, 5'h00, 8'h0F},  // R2 masked capture
    {1'b0, 5'h00, 8'h00, 8'h00, 5'h00, 8'h0F},  // R2 sticky
    {1'b1, 5'h03, 8'h05, 8'h00, 5'h00, 8'h0A},  // R5 partial clear
    {1'b1, 5'h03, 8'h02, 8'h02, 5'h00, 8'h0A},  // R6 event beats clear
    {1'b1, 5'h03, 8'hFF, 8'h00, 5'h03, 8'h00},  // R9 clear reads zero
    {1'b0, 5'h00, 8'h00, 8'h00, 5'h00, 8'h00},  // R5 full clear
    {1'b1, 5'h02, 8'h01, 8'h00, 5'h02, 8'h01},  // R9 raise readback
    {1'b1, 5'h01, 8'h00, 8'h00, 5'h00, 8'h00},  // R3 mask off
    {1'b0, 5'h00, 8'h00, 8'hFF, 5'h00, 8'h00},  // R3 events ignored
    {1'b1, 5'h01, 8'hF0, 8'h00, 5'h00, 8'h00},  // R2 new mask
    {1'b0, 5'h00, 8'h00, 8'h30, 5'h00, 8'h30},  // R2 errors captured
    {1'b1, 5'h05, 8'hFF, 8'h00, 5'h00, 8'h30}   // R10 other channel write
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [EVW-1:0] d,
                    input logic [NCH*EVW-1:0] ev);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; wdata_i = d; ev_i = ev;
    @(negedge clk);
    wr_i = 1'b0; ev_i = '0;
  endtask

  task automatic pulse(input logic [NCH*EVW-1:0] ev);
    @(negedge clk);
    ev_i = ev;
    @(negedge clk);
    ev_i = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [EVW-1:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  initial begin
    #(CLK_NS*5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [EVW-1:0] d;
    rst_n = 1'b0; ev_i = '0; wr_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 irq_o", irq_o, 0);
    chk("R1 irq_chan_o", irq_chan_o, 0);
    chk("R1 cause_o", cause_o, 0);
    for (int c = 0; c < NCH; c++) begin
      rd(AW'(c*4), d);     chk("R1 status", d, 0);
      rd(AW'(c*4+1), d);   chk("R1 record mask", d, 0);
      rd(AW'(c*4+2), d);   chk("R1 raise mask", d, 0);
    end
    rd(5'h10, d); chk("R1 global", d, 0);

    for (int i = 0; i < 14; i++) begin
      logic [34:0] v;
      v = VECS[i];
      @(negedge clk);
      wr_i = v[34]; addr_i = v[33:29]; wdata_i = v[28:21];
      ev_i = '0; ev_i[7:0] = v[20:13];
      @(negedge clk);
      wr_i = 1'b0; ev_i = '0;
      rd(v[12:8], d);
      chk($sformatf("table vector %0d", i), d, v[7:0]);
    end
    // R10 channel 1 got its own mask
    rd(5'h05, d); chk("R10 chan1 record", d, 8'hFF);
    rd(5'h09, d); chk("R10 chan2 record untouched", d, 0);
    // R8 chan0 holds errors 0x30
    chk("R8 chan0 error cause", cause_o[1:0], 2'b10);
    // R4 chan0 raise=0x01 but status 0x30
    chk("R4 chan0 line off", irq_chan_o[0], 0);

    // R4 suspend captured without signalling (chan2)
    wr(5'h09, 8'h02, '0);
    pulse(32'h0002_0000);
    rd(5'h08, d); chk("R4 suspend captured", d, 8'h02);
    chk("R4 suspend not raised", irq_chan_o[2], 0);
    wr(5'h0A, 8'h02, '0);
    chk("R4 suspend raised", irq_chan_o[2], 1);
    chk("R7 global off gates", irq_o, 0);

    // R7 global enable
    wr(5'h10, 8'h01, '0);
    chk("R7 global on", irq_o, 1);
    wr(5'h10, 8'h00, '0);
    chk("R7 global off again", irq_o, 0);
    rd(5'h08, d); chk("R7 status kept", d, 8'h02);

    // R8 priority on chan3
    wr(5'h0D, 8'hFF, '0);
    pulse(32'h0100_0000);
    chk("R8 done cause", cause_o[7:6], 2'b01);
    pulse(32'h8000_0000);
    chk("R8 error beats done", cause_o[7:6], 2'b10);
    wr(5'h0F, 8'h80, '0);
    chk("R8 back to done", cause_o[7:6], 2'b01);
    rd(5'h0C, d); chk("R5 chan3 status", d, 8'h01);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule